// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block sits beside the command pins of a four-bank single-data-rate SDRAM interface. It samples the pins on every rising clock edge. The pins are chip select, row strobe, column strobe, write enable, clock enable, A10, the bank address, and the three low address bits that carry the burst-length field of a mode-register write. From these it names the command. It then decides whether that command is allowed, given what every bank and the device as a whole are doing at that moment.

It tracks each bank as idle, opening, open, or closing on its own after a burst with auto-precharge. Each bank has a down-counter that holds off the next command until the programmed clock counts have elapsed. A device-wide counter covers refresh and mode-register waits. Two more counters cover spacing between row activations. Clock-enable low suspends the device and freezes all timers. A refresh pattern sampled with clock enable falling enters self refresh.

Each verdict appears one clock after the sampling edge. It consists of a command code, a legal flag, a one-cycle error pulse and the bank index of the offending command. An illegal command leaves all tracked state untouched. The checker suits protocol monitors and controller bring-up. It carries no memory array and no data path.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With chip select high the code is 0 (deselect). With chip select low, the {row, column, write} strobes decode as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read) or 4 (read with auto-precharge, when A10 is high), 100 gives 5 (write) or 6 (write with auto-precharge, when A10 is high), 010 gives 7 (precharge one bank) or 8 (precharge all, when A10 is high), 001 gives 9 (auto refresh, clock enable high) or 10 (self-refresh entry, clock enable low), 000 gives 11 (mode set) and 110 gives 12 (burst stop). Code 13 marks a suspended cycle. The verdict for the command sampled at edge n is visible after edge n and before edge n+1.
- R2: While reset is held, the outputs show code 1, legal high, no error pulse and error bank 0. The burst length resets to 4. Every bank resets to idle with no wait pending.
- R3: A read or write, plain or with auto-precharge, is legal only on an open bank at least T_RCD enabled cycles after its activate.
- R4: An activate is legal only on an idle bank at least T_RP enabled cycles after that bank's precharge. It must also come at least T_RRD enabled cycles after the previous activate to any bank. A third activate within any T_RC enabled cycles is illegal.
- R5: After a read with auto-precharge, every read, write, precharge, burst stop or activate to that bank is illegal until BL+T_RP enabled cycles have passed. From then on an activate to it is legal.
- R6: After a write with auto-precharge, the bank becomes available for an activate BL-1+T_WR+T_RP enabled cycles later, and not before.
- R7: A single-bank precharge is legal when the addressed bank is open and settled, or idle and settled. A precharge-all is legal only when no bank is opening, closing or auto-precharging, and it closes every open bank.
- R8: Auto refresh and mode set need every bank idle and settled. After an auto refresh, only deselect and no-op are legal for T_RC enabled cycles. After a mode set, the same holds for T_RSC enabled cycles.
- R9: A legal mode set latches the three mode bits as the burst code: 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8. Any code with bit 2 set means full page, under which read and write with auto-precharge are illegal.
- R10: Self-refresh entry needs every bank idle. Afterwards every cycle reports code 13 and legal until clock enable is sampled high. Only deselect and no-op are then legal for T_RC enabled cycles.
- R11: A cycle whose previous edge sampled clock enable low reports code 13 and legal. Its command is ignored and all timers hold.
- R12: An illegal command gives a one-cycle error pulse with legal low and the error bank equal to the bank pins. It changes no tracked state. In legal cycles the error bank reads 0.
- R13: A burst stop is legal only when the addressed bank is open and settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Auto-precharge / all-bank select |
| ba | input | BANK_W | Bank address |
| modeBits | input | 3 | Burst-length field sampled on mode set |
| cmdCode | output | 4 | Decoded command code of the previous edge |
| cmdLegal | output | 1 | High when that command was allowed |
| errPulse | output | 1 | One-cycle pulse on an illegal command |
| errBank | output | BANK_W | Bank index of the illegal command |

## Verification
The bench targets the exact cycle at which each wait ends. It probes read after activate, activate after an auto-precharge read or write, the third activate inside the window, and commands during refresh and mode-set waits. A design off by one in any counter shows a flipped legal flag on that single cycle. It also drives suspended cycles and a self-refresh exit. A design that let a suspended cycle's command through, or kept timers running while clock enable was low, would open a bank or free a bank early. Illegal commands on busy banks follow. A design that updated state on a rejected command would misjudge every later command to that bank.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_READ   = 4'd3,
    CMD_READA  = 4'd4,
    CMD_WRITE  = 4'd5,
    CMD_WRITEA = 4'd6,
    CMD_PRE    = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_REF    = 4'd9,
    CMD_SREF   = 4'd10,
    CMD_MRS    = 4'd11,
    CMD_BST    = 4'd12,
    CMD_SUSP   = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {BK_IDLE, BK_OPEN, BK_RDAP, BK_WRAP} bank_e;

  // strobes from the legality control into the timer datapath
  typedef struct packed {
    logic              tick;
    logic              act;
    logic              rd;
    logic              wr;
    logic              autoPre;
    logic              pre;
    logic              preAll;
    logic              refresh;
    logic              modeSet;
    logic              srExit;
    logic [BANK_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic a10,
  input  logic cke,
  output cmd_e cmd
);
  always_comb begin
    if (csN) begin
      cmd = CMD_DESEL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_READA : CMD_READ;
        3'b100:  cmd = a10 ? CMD_WRITEA : CMD_WRITE;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_timers.sv
module sdram_bank_timers
  import sdram_cmd_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RRD = 2,
  parameter int T_RC  = 9,
  parameter int T_WR  = 2,
  parameter int T_RSC = 2,
  parameter int BL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [BL_W-1:0]      burstCycles,
  output logic [NUM_BANKS-1:0] idleRdy,
  output logic [NUM_BANKS-1:0] openRdy,
  output logic                 actOk,
  output logic                 globalFree
);
  localparam int MAX_LOAD = (1 << BL_W) + T_WR + T_RP + T_RC + T_RSC + T_RCD + T_RRD;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic [CNT_W-1:0] rdApLoad, wrApLoad;
  assign rdApLoad = CNT_W'(burstCycles) + CNT_W'(T_RP - 1);
  assign wrApLoad = CNT_W'(burstCycles) + CNT_W'(T_WR + T_RP - 2);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_e            st;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    assign hit = (stb.bank == BANK_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st  <= BK_IDLE;
        cnt <= '0;
      end else begin
        if (stb.tick) begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (st == BK_RDAP || st == BK_WRAP) st <= BK_IDLE;
        end
        if (stb.act && hit) begin
          st  <= BK_OPEN;
          cnt <= CNT_W'(T_RCD - 1);
        end else if ((stb.rd || stb.wr) && stb.autoPre && hit) begin
          st  <= stb.rd ? BK_RDAP : BK_WRAP;
          cnt <= stb.rd ? rdApLoad : wrApLoad;
        end else if (stb.pre && (hit || stb.preAll) && st == BK_OPEN) begin
          st  <= BK_IDLE;
          cnt <= CNT_W'(T_RP - 1);
        end
      end
    end

    assign idleRdy[i] = (cnt == '0) && (st != BK_OPEN);
    assign openRdy[i] = (cnt == '0) && (st == BK_OPEN);
  end

  // device-wide wait after refresh, self-refresh exit and mode set
  logic [CNT_W-1:0] gCnt;
  always_ff @(posedge clk) begin
    if (!rstN) gCnt <= '0;
    else if (stb.refresh || stb.srExit) gCnt <= CNT_W'(T_RC - 1);
    else if (stb.modeSet) gCnt <= CNT_W'(T_RSC - 1);
    else if (stb.tick && gCnt != '0) gCnt <= gCnt - 1'b1;
  end
  assign globalFree = (gCnt == '0);

  // activate spacing and the two-per-window limit
  logic [CNT_W-1:0] rrdCnt, win0, win1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt <= '0;
      win0   <= '0;
      win1   <= '0;
    end else begin
      if (stb.tick) begin
        if (rrdCnt != '0) rrdCnt <= rrdCnt - 1'b1;
        if (win0 != '0) win0 <= win0 - 1'b1;
        if (win1 != '0) win1 <= win1 - 1'b1;
      end
      if (stb.act) begin
        rrdCnt <= CNT_W'(T_RRD - 1);
        if (win0 == '0) win0 <= CNT_W'(T_RC - 1);
        else win1 <= CNT_W'(T_RC - 1);
      end
    end
  end
  assign actOk = (rrdCnt == '0) && ((win0 == '0) || (win1 == '0));

  assert_act_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |-> (idleRdy[stb.bank] && actOk && globalFree));

  assert_col_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd || stb.wr) |-> openRdy[stb.bank]);

  assert_act_closes_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |=> !idleRdy[$past(stb.bank)]);

  assert_refresh_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.refresh && (T_RC > 1)) |=> !globalFree);
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmd_e                 decCmd,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 cke,
  input  logic [2:0]           modeBits,
  input  logic [NUM_BANKS-1:0] idleRdy,
  input  logic [NUM_BANKS-1:0] openRdy,
  input  logic                 actOk,
  input  logic                 globalFree,
  output strobe_t              stb,
  output logic [BL_W-1:0]      burstCycles,
  output cmd_e                 cmdCode,
  output logic                 cmdLegal,
  output logic                 errPulse,
  output logic [BANK_W-1:0]    errBank
);
  logic       ckePrev, selfRef;
  logic [2:0] blCode;
  logic       fullPage, allIdle, allSettled, legal;
  cmd_e       code;

  assign fullPage    = blCode[2];
  assign burstCycles = fullPage ? BL_W'(1) : (BL_W'(1) << blCode[1:0]);
  assign allIdle     = &idleRdy;
  assign allSettled  = &(idleRdy | openRdy);

  always_comb begin
    code     = decCmd;
    legal    = 1'b0;
    stb      = '0;
    stb.bank = ba;
    if (selfRef || !ckePrev) begin
      code       = CMD_SUSP;
      legal      = 1'b1;
      stb.srExit = selfRef && cke;
    end else begin
      stb.tick = 1'b1;
      case (decCmd)
        CMD_DESEL, CMD_NOP:     legal = 1'b1;
        CMD_ACT:                legal = globalFree && idleRdy[ba] && actOk;
        CMD_READ, CMD_WRITE:    legal = globalFree && openRdy[ba];
        CMD_READA, CMD_WRITEA:  legal = globalFree && openRdy[ba] && !fullPage;
        CMD_PRE:                legal = globalFree && (openRdy[ba] || idleRdy[ba]);
        CMD_PREA:               legal = globalFree && allSettled;
        CMD_REF, CMD_SREF, CMD_MRS: legal = globalFree && allIdle;
        CMD_BST:                legal = globalFree && openRdy[ba];
        default:                legal = 1'b0;
      endcase
      stb.act     = legal && (decCmd == CMD_ACT);
      stb.rd      = legal && (decCmd == CMD_READ || decCmd == CMD_READA);
      stb.wr      = legal && (decCmd == CMD_WRITE || decCmd == CMD_WRITEA);
      stb.autoPre = (decCmd == CMD_READA || decCmd == CMD_WRITEA);
      stb.pre     = legal && (decCmd == CMD_PRE || decCmd == CMD_PREA);
      stb.preAll  = (decCmd == CMD_PREA);
      stb.refresh = legal && (decCmd == CMD_REF);
      stb.modeSet = legal && (decCmd == CMD_MRS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev  <= 1'b1;
      selfRef  <= 1'b0;
      blCode   <= 3'b010;
      cmdCode  <= CMD_NOP;
      cmdLegal <= 1'b1;
      errPulse <= 1'b0;
      errBank  <= '0;
    end else begin
      ckePrev <= cke;
      if (stb.srExit) selfRef <= 1'b0;
      else if (legal && code == CMD_SREF) selfRef <= 1'b1;
      if (stb.modeSet) blCode <= modeBits;
      cmdCode  <= code;
      cmdLegal <= legal;
      errPulse <= !legal;
      errBank  <= legal ? '0 : ba;
    end
  end

  assert_sr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (selfRef && !cke) |=> (cmdCode == CMD_SUSP && cmdLegal && selfRef));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_cmd_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RRD = 2,
  parameter int T_RC  = 9,
  parameter int T_WR  = 2,
  parameter int T_RSC = 2,
  parameter int BL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic              a10,
  input  logic [BANK_W-1:0] ba,
  input  logic [2:0]        modeBits,
  output logic [3:0]        cmdCode,
  output logic              cmdLegal,
  output logic              errPulse,
  output logic [BANK_W-1:0] errBank
);
  cmd_e                 decCmd, outCode;
  strobe_t              stb;
  logic [BL_W-1:0]      burstCycles;
  logic [NUM_BANKS-1:0] idleRdy, openRdy;
  logic                 actOk, globalFree;

  sdram_cmd_decode u_decode (
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .cke(cke), .cmd(decCmd)
  );

  sdram_cmd_ctrl #(.BL_W(BL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .decCmd(decCmd), .ba(ba), .cke(cke),
    .modeBits(modeBits), .idleRdy(idleRdy), .openRdy(openRdy),
    .actOk(actOk), .globalFree(globalFree), .stb(stb),
    .burstCycles(burstCycles), .cmdCode(outCode), .cmdLegal(cmdLegal),
    .errPulse(errPulse), .errBank(errBank)
  );

  sdram_bank_timers #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
    .T_WR(T_WR), .T_RSC(T_RSC), .BL_W(BL_W)
  ) u_timers (
    .clk(clk), .rstN(rstN), .stb(stb), .burstCycles(burstCycles),
    .idleRdy(idleRdy), .openRdy(openRdy), .actOk(actOk),
    .globalFree(globalFree)
  );

  assign cmdCode = outCode;
endmodule

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
  localparam int P_RCD = 2, P_RP = 2, P_RRD = 2, P_RC = 6, P_WR = 2, P_RSC = 2;
  localparam int DESEL = 0, NOP = 1, ACT = 2, RD = 3, RDA = 4, WR = 5, WRA = 6,
                 PRE = 7, PREA = 8, REF = 9, SREF = 10, MRS = 11, BST = 12, SUSP = 13;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [2:0] modeBits = '0;
  logic [3:0] cmdCode;
  logic cmdLegal, errPulse;
  logic [1:0] errBank;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_checker #(.T_RCD(P_RCD), .T_RP(P_RP), .T_RRD(P_RRD), .T_RC(P_RC),
                      .T_WR(P_WR), .T_RSC(P_RSC)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .a10(a10), .ba(ba), .modeBits(modeBits), .cmdCode(cmdCode),
    .cmdLegal(cmdLegal), .errPulse(errPulse), .errBank(errBank));

  // behavioural reference: absolute enabled-cycle times, not counters
  int  nowCyc = 0;
  int  readyAt[4];
  bit  isOpen[4];
  int  actTimes[$];
  int  lastAct = -1000;
  int  busyUntil = 0;
  bit  mPrevCke = 1'b1, mSelf = 1'b0, mFull = 1'b0;
  int  mBl = 4;

  function automatic bit bIdle(int b);
    return !isOpen[b] && nowCyc >= readyAt[b];
  endfunction
  function automatic bit bOpen(int b);
    return isOpen[b] && nowCyc >= readyAt[b];
  endfunction

  task automatic model(input int c, input int b, input bit k, input logic [2:0] mb,
                       output int eCode, output bit eLegal);
    bit free, allIdle, allSet;
    int inWin;
    eCode = c;
    eLegal = 1'b0;
    if (mSelf || !mPrevCke) begin
      eCode = SUSP;
      eLegal = 1'b1;
      if (mSelf && k) begin
        mSelf = 1'b0;
        busyUntil = nowCyc + P_RC;
      end
    end else begin
      nowCyc++;
      free = nowCyc >= busyUntil;
      allIdle = 1'b1;
      allSet = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (!bIdle(i)) allIdle = 1'b0;
        if (!bIdle(i) && !bOpen(i)) allSet = 1'b0;
      end
      inWin = 0;
      foreach (actTimes[j]) if (nowCyc - actTimes[j] < P_RC) inWin++;
      case (c)
        DESEL, NOP: eLegal = 1'b1;
        ACT:        eLegal = free && bIdle(b) && (nowCyc >= lastAct + P_RRD) && (inWin < 2);
        RD, WR:     eLegal = free && bOpen(b);
        RDA, WRA:   eLegal = free && bOpen(b) && !mFull;
        PRE:        eLegal = free && (bOpen(b) || bIdle(b));
        PREA:       eLegal = free && allSet;
        REF, SREF, MRS: eLegal = free && allIdle;
        BST:        eLegal = free && bOpen(b);
        default:    eLegal = 1'b0;
      endcase
      if (eLegal) begin
        case (c)
          ACT: begin
            isOpen[b] = 1'b1; readyAt[b] = nowCyc + P_RCD;
            lastAct = nowCyc; actTimes.push_back(nowCyc);
          end
          RDA: begin isOpen[b] = 1'b0; readyAt[b] = nowCyc + mBl + P_RP; end
          WRA: begin isOpen[b] = 1'b0; readyAt[b] = nowCyc + mBl - 1 + P_WR + P_RP; end
          PRE: if (isOpen[b]) begin isOpen[b] = 1'b0; readyAt[b] = nowCyc + P_RP; end
          PREA: for (int i = 0; i < 4; i++)
                  if (isOpen[i]) begin isOpen[i] = 1'b0; readyAt[i] = nowCyc + P_RP; end
          REF: busyUntil = nowCyc + P_RC;
          MRS: begin busyUntil = nowCyc + P_RSC; mFull = mb[2]; mBl = 1 << mb[1:0]; end
          SREF: mSelf = 1'b1;
          default: ;
        endcase
      end
    end
    mPrevCke = k;
  endtask

  // pin patterns per R1
  task automatic drivePins(input int c, input int b, input bit k, input logic [2:0] mb);
    logic [2:0] rcw;
    csN = 1'b0; a10 = 1'b0; cke = k; ba = 2'(b); modeBits = mb;
    case (c)
      DESEL: begin csN = 1'b1; rcw = 3'b111; end
      ACT:   rcw = 3'b011;
      RD:    rcw = 3'b101;
      RDA:   begin rcw = 3'b101; a10 = 1'b1; end
      WR:    rcw = 3'b100;
      WRA:   begin rcw = 3'b100; a10 = 1'b1; end
      PRE:   rcw = 3'b010;
      PREA:  begin rcw = 3'b010; a10 = 1'b1; end
      REF, SREF: rcw = 3'b001;
      MRS:   rcw = 3'b000;
      BST:   rcw = 3'b110;
      default: rcw = 3'b111;
    endcase
    {rasN, casN, weN} = rcw;
  endtask

  task automatic step(input int c, input int b, input bit k, input logic [2:0] mb, input string tag);
    int eCode;
    bit eLegal;
    drivePins(c, b, k, mb);
    @(posedge clk);
    model(c, b, k, mb, eCode, eLegal);
    @(negedge clk);
    checks++;
    if (cmdCode !== 4'(eCode) || cmdLegal !== eLegal || errPulse !== !eLegal ||
        errBank !== (eLegal ? 2'd0 : 2'(b))) begin
      errors++;
      $display("FAIL %s: code=%0d exp %0d legal=%0b exp %0b err=%0b exp %0b bank=%0d exp %0d",
               tag, cmdCode, eCode, cmdLegal, eLegal, errPulse, !eLegal, errBank,
               eLegal ? 0 : b);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 0, 1'b1, 3'b000, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin readyAt[i] = 0; isOpen[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R2: reset state
    checks++;
    if (cmdCode !== 4'd1 || cmdLegal !== 1'b1 || errPulse !== 1'b0 || errBank !== 2'd0) begin
      errors++;
      $display("FAIL R2: code=%0d legal=%0b err=%0b bank=%0d exp 1 1 0 0",
               cmdCode, cmdLegal, errPulse, errBank);
    end
    rstN = 1'b1;

    step(NOP, 0, 1'b1, 3'b000, "R1");
    step(DESEL, 2, 1'b1, 3'b000, "R1");
    step(MRS, 0, 1'b1, 3'b010, "R9");
    step(ACT, 0, 1'b1, 3'b000, "R8");
    step(ACT, 0, 1'b1, 3'b000, "R4");
    step(RD, 0, 1'b1, 3'b000, "R3");
    step(ACT, 1, 1'b1, 3'b000, "R4");
    step(RD, 0, 1'b1, 3'b000, "R3");
    step(ACT, 2, 1'b1, 3'b000, "R4");
    step(ACT, 2, 1'b1, 3'b000, "R4");
    step(ACT, 2, 1'b1, 3'b000, "R4");
    step(ACT, 2, 1'b1, 3'b000, "R4");
    step(RD, 2, 1'b1, 3'b000, "R12");
    step(RDA, 0, 1'b1, 3'b000, "R5");
    step(RD, 0, 1'b1, 3'b000, "R5");
    step(PRE, 0, 1'b1, 3'b000, "R5");
    step(BST, 0, 1'b1, 3'b000, "R5");
    for (int i = 0; i < 5; i++) step(ACT, 0, 1'b1, 3'b000, "R5");
    step(WRA, 1, 1'b1, 3'b000, "R6");
    idle(3, "R6");
    for (int i = 0; i < 5; i++) step(ACT, 1, 1'b1, 3'b000, "R6");
    step(BST, 3, 1'b1, 3'b000, "R13");
    step(BST, 0, 1'b1, 3'b000, "R13");
    step(BST, 1, 1'b1, 3'b000, "R13");
    step(PREA, 0, 1'b1, 3'b000, "R7");
    step(PRE, 3, 1'b1, 3'b000, "R7");
    step(PREA, 0, 1'b1, 3'b000, "R7");
    step(PRE, 0, 1'b1, 3'b000, "R7");
    step(REF, 0, 1'b1, 3'b000, "R8");
    step(REF, 0, 1'b1, 3'b000, "R8");
    step(REF, 0, 1'b1, 3'b000, "R8");
    for (int i = 0; i < 7; i++) step(ACT, 0, 1'b1, 3'b000, "R8");
    step(PREA, 0, 1'b1, 3'b000, "R7");
    idle(3, "R7");
    step(MRS, 0, 1'b1, 3'b111, "R9");
    idle(2, "R9");
    step(ACT, 3, 1'b1, 3'b000, "R9");
    idle(2, "R9");
    step(RDA, 3, 1'b1, 3'b000, "R9");
    step(WRA, 3, 1'b1, 3'b000, "R9");
    step(RD, 3, 1'b1, 3'b000, "R9");
    step(NOP, 0, 1'b0, 3'b000, "R11");
    step(ACT, 0, 1'b0, 3'b000, "R11");
    step(ACT, 0, 1'b1, 3'b000, "R11");
    step(RD, 0, 1'b1, 3'b000, "R11");
    step(RD, 3, 1'b1, 3'b000, "R11");
    step(SREF, 0, 1'b0, 3'b000, "R10");
    step(NOP, 0, 1'b1, 3'b000, "R11");
    step(PREA, 0, 1'b1, 3'b000, "R7");
    idle(3, "R10");
    step(MRS, 0, 1'b1, 3'b001, "R9");
    idle(2, "R9");
    step(SREF, 0, 1'b0, 3'b000, "R10");
    for (int i = 0; i < 3; i++) step(ACT, 1, 1'b0, 3'b000, "R10");
    step(NOP, 0, 1'b1, 3'b000, "R10");
    for (int i = 0; i < 7; i++) step(ACT, 1, 1'b1, 3'b000, "R10");
    step(WRA, 1, 1'b1, 3'b000, "R6");
    for (int i = 0; i < 5; i++) step(ACT, 1, 1'b1, 3'b000, "R6");
    step(PRE, 1, 1'b1, 3'b000, "R12");
    step(MRS, 0, 1'b1, 3'b011, "R12");
    idle(2, "R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule